// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block is the interrupt front end for sixteen general-purpose input pins. Each pin is first brought into the clock domain by a two-flop synchronizer. Its synchronized value is then compared with the value from the previous clock to find transitions. A per-pin mode bit chooses between two policies: report every level change, or report only falling transitions. A detected transition sets a sticky pending bit. Software clears that bit by writing a one to it.

A per-pin enable mask gates the pending bits into a single registered interrupt request. Pending bits latch whether or not the pin is enabled, so software can poll masked pins. Three 32-bit words hold the configuration and status; only the low sixteen bit positions of each word are implemented. A simple register port reads and writes these words: write strobe, byte address, write data, and combinational read data.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the enable word (0xC10), the mode word (0xC14) and the pending word (0xC0C) all read zero, and irq_o is low.
- R2: With a pin's mode bit at 0, both a rising and a falling change on that pin set its pending bit.
- R3: With a pin's mode bit at 1, a falling change sets its pending bit and a rising change leaves it clear.
- R4: Pending bits latch even when the pin's enable bit is 0, and in that case irq_o stays low.
- R5: irq_o equals the OR over all pins of (pending AND enable) as sampled at the previous clock edge, so it follows a write to the enable word or the pending word one cycle later.
- R6: Writing 1 to a bit of the pending word at 0xC0C clears that bit, and writing 0 leaves it unchanged.
- R7: When a new event on a pin occurs at the same clock edge as a write-one-to-clear of that pin's bit, the bit stays set.
- R8: Bits 31 to 16 of every word read as zero, and writes to them have no effect.
- R9: Changing a pin's mode bit while the pin is steady does not set its pending bit.
- R10: Writes to any address other than 0xC0C, 0xC10 and 0xC14 change no state, and reads from such addresses return zero.
- R11: A level change on pins_i that is stable across a clock edge shows in the pending word after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 16 | Asynchronous general-purpose input pins |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 12 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong synchronizer depth or edge-comparison stage shifts the cycle in which the pending word changes. The bench therefore reads that word exactly two and three rising edges after a pin change. A mode decode that is wrong shows at once as a pending bit that sets, or stays clear, when it should not after a rising edge. A mode-to-event path that depends on stale state would show as a pending bit after the mode word alone is rewritten. Faults in the mask gate or in the interrupt register appear on irq_o one cycle after the pending or enable word is written. The bench samples irq_o both one cycle and two cycles after that write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFS_PEND = 32'h0000_0C0C;
  localparam int unsigned OFS_EN   = 32'h0000_0C10;
  localparam int unsigned OFS_MODE = 32'h0000_0C14;
  localparam int unsigned DEF_PINS = 16;
  localparam int unsigned DEF_DW   = 32;
  localparam int unsigned DEF_AW   = 12;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] fall_only_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] prev_q;

  // previous value tracks the pin in every mode, so a mode write alone cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign evt_o[i] = fall_only_i[i] ? (prev_q[i] & ~cur_i[i]) : (prev_q[i] ^ cur_i[i]);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = DEF_PINS,
  parameter int unsigned DATA_W   = DEF_DW,
  parameter int unsigned ADDR_W   = DEF_AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] evt_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  logic sel_pend, sel_en, sel_mode;
  logic [NUM_PINS-1:0] en_q, mode_q, pend_q, wbits;
  logic unused_wdata;

  assign sel_pend = addr_i == ADDR_W'(OFS_PEND);
  assign sel_en   = addr_i == ADDR_W'(OFS_EN);
  assign sel_mode = addr_i == ADDR_W'(OFS_MODE);
  assign wbits    = wdata_i[NUM_PINS-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_PINS];

  assign clr_o = (we_i && sel_pend) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
      pend_q <= '0;
    end else begin
      if (we_i && sel_en)   en_q   <= wbits;
      if (we_i && sel_mode) mode_q <= wbits;
      // new event wins over a simultaneous clear
      pend_q <= (pend_q & ~clr_o) | evt_i;
    end
  end

  always_comb begin
    unique case (1'b1)
      sel_pend: rdata_o = {{PAD_W{1'b0}}, pend_q};
      sel_en:   rdata_o = {{PAD_W{1'b0}}, en_q};
      sel_mode: rdata_o = {{PAD_W{1'b0}}, mode_q};
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = DEF_PINS,
  parameter int unsigned DATA_W      = DEF_DW,
  parameter int unsigned ADDR_W      = DEF_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pins_s, evt, mask_q, mode_q, pend_q, clr_vec;
  logic irq_q;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  gpio_edge_det #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (pins_s),
    .fall_only_i(mode_q),
    .evt_o      (evt)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .evt_i  (evt),
    .en_o   (mask_q),
    .mode_o (mode_q),
    .pend_o (pend_q),
    .clr_o  (clr_vec),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_q & mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_i,
  input logic [DATA_W-1:0]   rdata_i,
  input logic [NUM_PINS-1:0] pend_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] evt_i,
  input logic [NUM_PINS-1:0] clr_i
);
  assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_i & mask_i)) |=> irq_i);

  assert_irq_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend_i & mask_i)) |=> !irq_i);

  assert_evt_latches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_i & $past(evt_i)) == $past(evt_i)));

  assert_clear_works_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~evt_i)) |=> ((pend_i & $past(clr_i & ~evt_i)) == '0));

  assert_no_spurious_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~pend_i)) |=> ((pend_i & ~$past(pend_i) & ~$past(evt_i)) == '0));

  assert_clear_loses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & evt_i)) |=> ((pend_i & $past(clr_i & evt_i)) == $past(clr_i & evt_i)));

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |-> (rdata_i[DATA_W-1:NUM_PINS] == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_i  (irq_o),
  .rdata_i(rdata_o),
  .pend_i (pend_q),
  .mask_i (mask_q),
  .evt_i  (evt),
  .clr_i  (clr_vec)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int unsigned NP = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] A_PEND = 12'hC0C;
  localparam logic [AW-1:0] A_EN   = 12'hC10;
  localparam logic [AW-1:0] A_MODE = 12'hC14;
  localparam logic [AW-1:0] A_BAD  = 12'hC18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pins_i (pins),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  // drive pins, wait through sync and edge stage, land on a negedge
  task automatic drive_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd("R1", A_EN, 32'h0);
    rd("R1", A_MODE, 32'h0);
    rd("R1", A_PEND, 32'h0);
    chk("R1", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_any_change();
    drive_pins(16'h0001);
    rd("R2", A_PEND, 32'h1);
    wr(A_PEND, 32'h1);
    rd("R6", A_PEND, 32'h0);
    drive_pins(16'h0000);
    rd("R2", A_PEND, 32'h1);
    wr(A_PEND, 32'h0);
    rd("R6", A_PEND, 32'h1);
    wr(A_PEND, 32'hFFFF);
    rd("R6", A_PEND, 32'h0);
  endtask

  task automatic t_fall_only();
    wr(A_MODE, 32'h0004);
    rd("R3", A_MODE, 32'h4);
    drive_pins(16'h0004);
    rd("R3", A_PEND, 32'h0);
    drive_pins(16'h0000);
    rd("R3", A_PEND, 32'h4);
    wr(A_PEND, 32'hFFFF);
    wr(A_MODE, 32'h0);
  endtask

  task automatic t_mask_irq();
    drive_pins(16'h0008);
    @(posedge clk); @(negedge clk);
    rd("R4", A_PEND, 32'h8);
    chk("R4", {31'h0, irq}, 32'h0);
    @(negedge clk);
    we = 1'b1; addr = A_EN; wdata = 32'h8;
    @(negedge clk);
    we = 1'b0;
    chk("R5", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R5", {31'h0, irq}, 32'h1);
    @(negedge clk);
    we = 1'b1; addr = A_PEND; wdata = 32'h8;
    @(negedge clk);
    we = 1'b0;
    chk("R5", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R5", {31'h0, irq}, 32'h0);
    drive_pins(16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R5", {31'h0, irq}, 32'h1);
    wr(A_EN, 32'h0);
    @(negedge clk);
    chk("R4", {31'h0, irq}, 32'h0);
    wr(A_PEND, 32'hFFFF);
  endtask

  task automatic t_collide();
    drive_pins(16'h0010);
    rd("R7", A_PEND, 32'h10);
    @(negedge clk);
    pins = 16'h0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    we = 1'b1; addr = A_PEND; wdata = 32'h10;
    @(negedge clk);
    we = 1'b0;
    rd("R7", A_PEND, 32'h10);
    wr(A_PEND, 32'h10);
    rd("R7", A_PEND, 32'h0);
  endtask

  task automatic t_upper_bits();
    wr(A_EN, 32'hFFFF_0000);
    rd("R8", A_EN, 32'h0);
    wr(A_MODE, 32'hFFFF_FFFF);
    rd("R8", A_MODE, 32'h0000_FFFF);
    wr(A_MODE, 32'h0);
  endtask

  task automatic t_bad_addr();
    wr(A_EN, 32'h0000_00A5);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd("R10", A_BAD, 32'h0);
    rd("R10", A_EN, 32'hA5);
    rd("R10", A_MODE, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_mode_flip();
    drive_pins(16'h0002);
    wr(A_PEND, 32'hFFFF);
    wr(A_MODE, 32'h0002);
    repeat (4) @(negedge clk);
    rd("R9", A_PEND, 32'h0);
    wr(A_MODE, 32'h0);
    repeat (4) @(negedge clk);
    rd("R9", A_PEND, 32'h0);
    drive_pins(16'h0000);
    wr(A_PEND, 32'hFFFF);
  endtask

  task automatic t_latency();
    @(negedge clk);
    pins = 16'h0020;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd("R11", A_PEND, 32'h0);
    @(negedge clk);
    rd("R11", A_PEND, 32'h20);
    drive_pins(16'h0000);
    wr(A_PEND, 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_any_change();
    t_fall_only();
    t_mask_irq();
    t_collide();
    t_upper_bits();
    t_bad_addr();
    t_mode_flip();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule